// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside a SECDED checker and keeps a record of the first memory error it reports. The checker sends a one-cycle pulse for a corrected (single-bit) error or for an uncorrected (multi-bit) error. With each pulse it also supplies the failing physical address and the 8-bit syndrome. When capture is armed, the block stores the upper address bits and the syndrome in one 32-bit status word and raises a sticky flag for the kind of error seen. Until software re-arms it, the block ignores any later error.

Software reads the word at any time through a simple read/write port with byte enables. Writing a one to either status flag clears both flags and re-arms capture. The same word holds three control bits:

- one that suppresses the scrub qualifier for corrected reads,
- one that enables an NMI request on a captured corrected error,
- one that enables a bus-error request on a captured uncorrected error.

Top module: `eccErrCapture`

## Requirements
- R1: After reset the status word reads 0x00000000, and `nmiReq`, `busErrReq` and `scrubReq` are low.
- R2: A `ceErr` pulse while armed (both flags 0) sets bit 0 on the next clock. In that same cycle it latches `errAddr[31:13]` into bits 30:12 and `errSyn` into bits 11:4.
- R3: A `ueErr` pulse while armed sets bit 1 and latches the address and syndrome in the same way as R2.
- R4: When `ceErr` and `ueErr` arrive in the same cycle while armed, only bit 1 is set, and the address and syndrome of that cycle are stored.
- R5: While either flag is set, new error pulses change nothing: the other flag stays 0, and bits 30:4 keep their captured value.
- R6: A write with `regBe[0]`=1 and a one in data bit 0 or bit 1 clears both flags. The captured address and syndrome are kept until the next capture.
- R7: Writing zeros to bits 1:0 leaves the flags unchanged. A write without `regBe[0]` leaves the flags unchanged whatever the data.
- R8: Bits 30:4 ignore writes.
- R9: When a clear write and an error pulse arrive in the same cycle, the clear takes effect first and the new error is captured.
- R10: Bit 2 (NMI enable) and bit 3 (bus-error enable) are read/write under `regBe[0]`. Bit 31 (scrub suppress) is read/write under `regBe[3]`.
- R11: `scrubReq` is high exactly when `ceErr` is high and bit 31 is 0.
- R12: `nmiReq` is high while bit 0 and bit 2 are both 1.
- R13: `busErrReq` is high while bit 1 and bit 3 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceErr | input | 1 | Corrected-error pulse from checker |
| ueErr | input | 1 | Uncorrected-error pulse from checker |
| errAddr | input | 32 | Physical address of the checked access |
| errSyn | input | 8 | Syndrome of the checked access |
| regWr | input | 1 | Register write strobe |
| regBe | input | 4 | Byte enables for the write |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Current status word |
| scrubReq | output | 1 | Qualified scrub request for a corrected read |
| nmiReq | output | 1 | NMI request level |
| busErrReq | output | 1 | Bus-error request level |

## Verification
The bench applies several kinds of error patterns:

- **Lone pulses of each kind from the armed state.** These show that each error type sets its own flag and that the address and syndrome land in the right bit positions.
- **A pulse that arrives while a flag is already set.** This shows whether the block truly keeps only the first error.
- **Both pulses in the same cycle.** This separates priority to the uncorrected error from a simple OR of the two.
- **A clear write and a pulse in the same cycle.** This separates clear-then-capture from capture being blocked.
- **Writes with partial byte enables and writes of zeros.** These show that flag clearing and control updates follow the lanes, and that read-only fields stay put.

// File: rtl/eccCapPkg.sv
package eccCapPkg;
  // Strobes from control to the capture datapath
  typedef struct packed {
    logic capture;  // latch address and syndrome this cycle
    logic clear;    // flags being cleared by software this cycle
  } capStrobe_t;
endpackage

// File: rtl/eccCapData.sv
module eccCapData
  import eccCapPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8,
  parameter int TAG_W  = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strobe,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic [SYN_W-1:0]  errSyn,
  output logic [TAG_W-1:0]  tagQ,
  output logic [SYN_W-1:0]  synQ
);
  localparam int TAG_LSB = ADDR_W - TAG_W;

  wire unusedLowAddr = ^errAddr[TAG_LSB-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagQ <= '0;
      synQ <= '0;
    end else if (strobe.capture) begin
      tagQ <= errAddr[ADDR_W-1:TAG_LSB];
      synQ <= errSyn;
    end
  end

  AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (tagQ == $past(errAddr[ADDR_W-1:TAG_LSB]) && synQ == $past(errSyn))); // R2

  AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capture || strobe.clear && !strobe.capture) |=> ($stable(tagQ) && $stable(synQ))); // R5
endmodule

// File: rtl/eccCapCtl.sv
module eccCapCtl
  import eccCapPkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceErr,
  input  logic             ueErr,
  input  logic             regWr,
  input  logic [REG_W/8-1:0] regBe,
  input  logic [3:0]       lane0Data,
  input  logic             topBit,
  output capStrobe_t       strobe,
  output logic             sbeQ,
  output logic             mbeQ,
  output logic             nmiEnQ,
  output logic             busErrEnQ,
  output logic             scrubOffQ
);
  logic wrLow, wrHigh, clearReq, armed, capture;

  assign wrLow    = regWr && regBe[0];
  assign wrHigh   = regWr && regBe[REG_W/8-1];
  assign clearReq = wrLow && (lane0Data[0] || lane0Data[1]);
  // clear resolves before capture in the same cycle
  assign armed    = clearReq || !(sbeQ || mbeQ);
  assign capture  = armed && (ceErr || ueErr);

  assign strobe.capture = capture;
  assign strobe.clear   = clearReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sbeQ      <= 1'b0;
      mbeQ      <= 1'b0;
      nmiEnQ    <= 1'b0;
      busErrEnQ <= 1'b0;
      scrubOffQ <= 1'b0;
    end else begin
      if (capture) begin
        mbeQ <= ueErr;
        sbeQ <= !ueErr;
      end else if (clearReq) begin
        mbeQ <= 1'b0;
        sbeQ <= 1'b0;
      end
      if (wrLow) begin
        nmiEnQ    <= lane0Data[2];
        busErrEnQ <= lane0Data[3];
      end
      if (wrHigh) scrubOffQ <= topBit;
    end
  end

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !(sbeQ && mbeQ)); // R5

  AST_MBE_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (armed && ueErr) |=> (mbeQ && !sbeQ)); // R4

  AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    ((sbeQ || mbeQ) && !clearReq) |=> ($stable(sbeQ) && $stable(mbeQ))); // R5

  AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (clearReq && !ceErr && !ueErr) |=> (!sbeQ && !mbeQ)); // R6

  AST_CLEAR_THEN_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (clearReq && ceErr && !ueErr) |=> (sbeQ && !mbeQ)); // R9
endmodule

// File: rtl/eccErrCapture.sv
module eccErrCapture
  import eccCapPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceErr,
  input  logic              ueErr,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic [SYN_W-1:0]  errSyn,
  input  logic              regWr,
  input  logic [3:0]        regBe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              scrubReq,
  output logic              nmiReq,
  output logic              busErrReq
);
  localparam int REG_W = 32;
  localparam int CTL_W = 4;                       // flags and enables in lane 0
  localparam int TAG_W = REG_W - 1 - CTL_W - SYN_W;

  capStrobe_t         strobe;
  logic               sbeQ, mbeQ, nmiEnQ, busErrEnQ, scrubOffQ;
  logic [TAG_W-1:0]   tagQ;
  logic [SYN_W-1:0]   synQ;

  wire unusedRoData = ^regWdata[REG_W-2:CTL_W];

  eccCapCtl #(.REG_W(REG_W)) ctl (
    .clk       (clk),
    .rstN      (rstN),
    .ceErr     (ceErr),
    .ueErr     (ueErr),
    .regWr     (regWr),
    .regBe     (regBe),
    .lane0Data (regWdata[CTL_W-1:0]),
    .topBit    (regWdata[REG_W-1]),
    .strobe    (strobe),
    .sbeQ      (sbeQ),
    .mbeQ      (mbeQ),
    .nmiEnQ    (nmiEnQ),
    .busErrEnQ (busErrEnQ),
    .scrubOffQ (scrubOffQ)
  );

  eccCapData #(.ADDR_W(ADDR_W), .SYN_W(SYN_W), .TAG_W(TAG_W)) dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .errAddr (errAddr),
    .errSyn  (errSyn),
    .tagQ    (tagQ),
    .synQ    (synQ)
  );

  assign regRdata  = {scrubOffQ, tagQ, synQ, busErrEnQ, nmiEnQ, mbeQ, sbeQ};
  assign scrubReq  = ceErr && !scrubOffQ;
  assign nmiReq    = sbeQ && nmiEnQ;
  assign busErrReq = mbeQ && busErrEnQ;

  AST_NMI_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> (regRdata[0] && regRdata[2])); // R12

  AST_BUSERR_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    busErrReq |-> (regRdata[1] && regRdata[3])); // R13

  AST_SCRUB_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    scrubReq |-> (ceErr && !regRdata[31])); // R11
endmodule

// File: tb/eccErrCapture_test.sv
module eccErrCapture_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceErr = 1'b0, ueErr = 1'b0, regWr = 1'b0;
  logic [31:0] errAddr = '0, regWdata = '0;
  logic [7:0]  errSyn = '0;
  logic [3:0]  regBe = '0;
  logic [31:0] regRdata;
  logic        scrubReq, nmiReq, busErrReq;
  int          nChecks = 0, nFails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  eccErrCapture uut (
    .clk(clk), .rstN(rstN), .ceErr(ceErr), .ueErr(ueErr), .errAddr(errAddr),
    .errSyn(errSyn), .regWr(regWr), .regBe(regBe), .regWdata(regWdata),
    .regRdata(regRdata), .scrubReq(scrubReq), .nmiReq(nmiReq), .busErrReq(busErrReq)
  );

  // {ce, ue, addr, syn, wr, be, wdata, expected word}
  localparam int NV = 13;
  localparam logic [110:0] VEC [0:NV-1] = '{
    {1'b1, 1'b0, 32'hA5A5E000, 8'h3C, 1'b0, 4'h0, 32'h00000000, 32'h52D2F3C1}, // R2
    {1'b0, 1'b1, 32'hFFFFFFFF, 8'hFF, 1'b0, 4'h0, 32'h00000000, 32'h52D2F3C1}, // R5
    {1'b1, 1'b0, 32'h12345678, 8'h11, 1'b0, 4'h0, 32'h00000000, 32'h52D2F3C1}, // R5
    {1'b0, 1'b0, 32'h0,        8'h00, 1'b1, 4'h0, 32'h00000003, 32'h52D2F3C1}, // R7
    {1'b0, 1'b0, 32'h0,        8'h00, 1'b1, 4'h1, 32'h00000000, 32'h52D2F3C1}, // R7
    {1'b0, 1'b0, 32'h0,        8'h00, 1'b1, 4'h1, 32'h00000002, 32'h52D2F3C0}, // R6
    {1'b1, 1'b1, 32'h80002000, 8'h81, 1'b0, 4'h0, 32'h00000000, 32'h40001812}, // R4
    {1'b1, 1'b0, 32'h00004000, 8'h5A, 1'b1, 4'h1, 32'h00000001, 32'h000025A1}, // R9
    {1'b0, 1'b0, 32'h0,        8'h00, 1'b1, 4'hF, 32'hFFFFFFFC, 32'h800025AD}, // R8 R10
    {1'b0, 1'b0, 32'h0,        8'h00, 1'b1, 4'h1, 32'h00000001, 32'h800025A0}, // R6
    {1'b0, 1'b1, 32'hFFFFE000, 8'h00, 1'b0, 4'h0, 32'h00000000, 32'hFFFFF002}, // R3
    {1'b0, 1'b0, 32'h0,        8'h00, 1'b1, 4'h8, 32'h00000000, 32'h7FFFF002}, // R10
    {1'b0, 1'b0, 32'h0,        8'h00, 1'b1, 4'h1, 32'h00000003, 32'h7FFFF000}  // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus at the falling edge, return idle after the rising edge
  task automatic step(input logic ce, input logic ue, input logic [31:0] a, input logic [7:0] s,
                      input logic wr, input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    ceErr = ce; ueErr = ue; errAddr = a; errSyn = s;
    regWr = wr; regBe = be; regWdata = wd;
    @(negedge clk);
    ceErr = 1'b0; ueErr = 1'b0; regWr = 1'b0; regBe = '0; regWdata = '0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 word", regRdata, 32'h0);
    check("R1 outs", {29'd0, scrubReq, nmiReq, busErrReq}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][110], VEC[i][109], VEC[i][108:77], VEC[i][76:69],
           VEC[i][68], VEC[i][67:64], VEC[i][63:32]);
      check($sformatf("vector %0d", i), regRdata, VEC[i][31:0]);
    end

    // R12: NMI follows flag and enable
    step(1'b0, 1'b0, 0, 0, 1'b1, 4'h1, 32'h00000004);
    check("R12 idle", {31'd0, nmiReq}, 32'h0);
    step(1'b1, 1'b0, 32'h00010000, 8'h07, 1'b0, 4'h0, 0);
    check("R12 nmi", {30'd0, nmiReq, busErrReq}, 32'h2);
    step(1'b0, 1'b1, 32'h00020000, 8'h09, 1'b0, 4'h0, 0);
    check("R13 blocked", {30'd0, nmiReq, busErrReq}, 32'h2);
    step(1'b0, 1'b0, 0, 0, 1'b1, 4'h1, 32'h00000005);
    check("R12 cleared", {31'd0, nmiReq}, 32'h0);

    // R13: bus-error follows flag and enable
    step(1'b0, 1'b0, 0, 0, 1'b1, 4'h1, 32'h00000008);
    step(1'b0, 1'b1, 32'h00030000, 8'h0B, 1'b0, 4'h0, 0);
    check("R13 buserr", {30'd0, nmiReq, busErrReq}, 32'h1);
    step(1'b0, 1'b0, 0, 0, 1'b1, 4'h1, 32'h0000000A);
    check("R13 cleared", {31'd0, busErrReq}, 32'h0);

    // R11: scrub qualifier is combinational on ceErr
    @(negedge clk);
    ceErr = 1'b1; #1;
    check("R11 scrub on", {31'd0, scrubReq}, 32'h1);
    ueErr = 1'b0; @(negedge clk); ceErr = 1'b0; #1;
    check("R11 scrub idle", {31'd0, scrubReq}, 32'h0);
    step(1'b0, 1'b0, 0, 0, 1'b1, 4'h8, 32'h80000000);
    @(negedge clk);
    ceErr = 1'b1; #1;
    check("R11 scrub off", {31'd0, scrubReq}, 32'h0);
    @(negedge clk); ceErr = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule